// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Loader

This block keeps the code registers of a two-channel digital-to-analog converter. Every channel owns a pending (input) code and a live (active) code. Bytes from the serial front end arrive on a byte-wide internal write bus. Each byte carries its own 7-bit address, and the front end walks multi-byte registers from the highest address down. Pending codes change only the input registers. The live codes that drive the converter change only when a trigger fires. A trigger is either a masked software trigger write or a falling edge on an active-low hardware trigger pin.

Codes can be written through two address windows. In the wide window each code register spans three bytes. In the narrow window each code register spans two bytes and is truncated to 12 bits. A broadcast (page) register writes one code into every channel marked in a channel-select register. A single descending burst can load both channels and trigger them in one frame. A power register turns off each channel's converter and amplifier flags. A powered-down converter outputs a zero code, but its stored codes are kept.

Top module: `dacld_top`

## Requirements
- R1: After reset all input and active codes are zero, every power-down bit is clear, and so `dac_en_o` and `amp_en_o` are all ones.
- R2: In the wide window, channel n's input register occupies addresses 0x48+3n (code MSB), 0x47+3n (code LSB) and 0x46+3n (ignored). A write to the input register does not change `dac_code_o` until a trigger fires.
- R3: In the narrow window, channel n's input register occupies 0x34+2n (MSB) and 0x33+2n (LSB). The stored code keeps bits 15:4 and forces bits 3:0 to zero.
- R4: A byte written to 0x45 or 0x32 is a software trigger. Bit n of the byte copies channel n's input code into its active code. Channels with a clear bit keep their active code. The copy shows on `dac_code_o` right after the clock edge that takes the byte.
- R5: A falling edge on `hw_trig_n` passes through two synchroniser flops and then copies every channel. The new codes appear after the third rising clock edge from the fall. Holding the pin low does not copy again.
- R6: A code written to the page register is stored into each channel whose bit n is set in the channel-select register. The channel-select register is at 0x41 or 0x2F, with bit n for channel n. The page register is at 0x44 (MSB) and 0x43 (LSB) with 0x42 ignored, or at 0x31 (MSB) and 0x30 (LSB) with narrow truncation. Unselected channels keep their input code.
- R7: A burst of seven consecutive bytes at 0x4B down to 0x45 loads channel 1, then loads channel 0, then applies the trigger byte.
- R8: In register 0x18, bit 4+n set powers down channel n's converter. `dac_en_o[n]` then drops and the channel's code output reads zero. Clearing the bit restores the kept active code.
- R9: In register 0x18, bit n set drops `amp_en_o[n]`.
- R10: If a hardware trigger copy and a software trigger land on the same edge, the result equals one copy of every channel.
- R11: Writes to addresses outside the map, and to the ignored third byte of a wide register, change no stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Byte write strobe from the front end |
| bus_addr | input | 7 | Register address of the byte |
| bus_wdata | input | 8 | Write byte |
| hw_trig_n | input | 1 | Asynchronous active-low hardware trigger |
| dac_code_o | output | 32 | Live codes, channel n at bits 16n+15:16n |
| dac_en_o | output | 2 | Converter enable per channel |
| amp_en_o | output | 2 | Amplifier enable per channel |

## Verification
The bench loads pending codes and first confirms that the live outputs have not moved. A design without double buffering would show the new code at once. Narrow-window loads are checked for the zeroed low nibble, and page writes are checked for leaving unselected channels alone. A broadcast applied to all channels, or a missing truncation, shows up as a wrong code. The hardware trigger is sampled one cycle before and at the cycle its copy is due, and is held low to catch a level-sensitive copy. It is also made to coincide with a software trigger, and power-down is toggled to confirm that the stored code survives.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
    localparam int NUM_CH      = 2;
    localparam int CODE_W      = 16;
    localparam int ADDR_W      = 7;
    localparam int BYTE_W      = 8;
    localparam int NARROW_DROP = 4;
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int STRIDE_W    = 3;
    localparam int STRIDE_N    = 2;
    localparam int PD_DAC_LSB  = 4;

    localparam logic [ADDR_W-1:0] ADR_PWR    = 7'h18;
    localparam logic [ADDR_W-1:0] ADR_SEL_N  = 7'h2F;
    localparam logic [ADDR_W-1:0] ADR_PAGE_N = 7'h31;
    localparam logic [ADDR_W-1:0] ADR_TRIG_N = 7'h32;
    localparam logic [ADDR_W-1:0] ADR_IN_N0  = 7'h34;
    localparam logic [ADDR_W-1:0] ADR_SEL_W  = 7'h41;
    localparam logic [ADDR_W-1:0] ADR_PAGE_W = 7'h44;
    localparam logic [ADDR_W-1:0] ADR_TRIG_W = 7'h45;
    localparam logic [ADDR_W-1:0] ADR_IN_W0  = 7'h48;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_INPUT, TGT_PAGE, TGT_SEL, TGT_TRIG, TGT_PWR
    } tgt_e;

    typedef struct packed {
        tgt_e            tgt;
        logic            top;
        logic            wide;
        logic [CH_W-1:0] ch;
    } slot_t;

    function automatic slot_t classify(input logic [ADDR_W-1:0] a);
        slot_t s;
        s.tgt  = TGT_NONE;
        s.top  = 1'b0;
        s.wide = 1'b0;
        s.ch   = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (a == ADR_IN_W0 + ADDR_W'(STRIDE_W * c)) begin
                s.tgt = TGT_INPUT; s.top = 1'b1; s.wide = 1'b1; s.ch = CH_W'(c);
            end
            if (a == ADR_IN_W0 + ADDR_W'(STRIDE_W * c) - 7'd1) begin
                s.tgt = TGT_INPUT; s.top = 1'b0; s.wide = 1'b1; s.ch = CH_W'(c);
            end
            if (a == ADR_IN_N0 + ADDR_W'(STRIDE_N * c)) begin
                s.tgt = TGT_INPUT; s.top = 1'b1; s.wide = 1'b0; s.ch = CH_W'(c);
            end
            if (a == ADR_IN_N0 + ADDR_W'(STRIDE_N * c) - 7'd1) begin
                s.tgt = TGT_INPUT; s.top = 1'b0; s.wide = 1'b0; s.ch = CH_W'(c);
            end
        end
        if (a == ADR_PAGE_W)        begin s.tgt = TGT_PAGE; s.top = 1'b1; s.wide = 1'b1; end
        if (a == ADR_PAGE_W - 7'd1) begin s.tgt = TGT_PAGE; s.top = 1'b0; s.wide = 1'b1; end
        if (a == ADR_PAGE_N)        begin s.tgt = TGT_PAGE; s.top = 1'b1; s.wide = 1'b0; end
        if (a == ADR_PAGE_N - 7'd1) begin s.tgt = TGT_PAGE; s.top = 1'b0; s.wide = 1'b0; end
        if (a == ADR_SEL_W || a == ADR_SEL_N)   s.tgt = TGT_SEL;
        if (a == ADR_TRIG_W || a == ADR_TRIG_N) s.tgt = TGT_TRIG;
        if (a == ADR_PWR)                       s.tgt = TGT_PWR;
        return s;
    endfunction
endpackage

// File: rtl/dacld_regif.sv
module dacld_regif
    import dacld_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int CW    = CODE_W,
    parameter int DROPB = NARROW_DROP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [NCH-1:0]    load_we,
    output logic [CW-1:0]     load_code,
    output logic [NCH-1:0]    trig_mask,
    output logic [NCH-1:0]    sel_q,
    output logic [NCH-1:0]    dac_pd_q,
    output logic [NCH-1:0]    amp_pd_q
);
    localparam logic [CW-1:0] KEEP_NARROW = ~CW'((1 << DROPB) - 1);

    slot_t             slot;
    logic [BYTE_W-1:0] stage_q;
    logic [CW-1:0]     code_full;

    assign slot      = classify(bus_addr);
    assign code_full = {stage_q, bus_wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            sel_q    <= '0;
            dac_pd_q <= '0;
            amp_pd_q <= '0;
        end else if (bus_we) begin
            if (slot.top && (slot.tgt == TGT_INPUT || slot.tgt == TGT_PAGE))
                stage_q <= bus_wdata;
            if (slot.tgt == TGT_SEL)
                sel_q <= bus_wdata[NCH-1:0];
            if (slot.tgt == TGT_PWR) begin
                dac_pd_q <= bus_wdata[PD_DAC_LSB +: NCH];
                amp_pd_q <= bus_wdata[0 +: NCH];
            end
        end
    end

    always_comb begin
        load_we   = '0;
        load_code = slot.wide ? code_full : (code_full & KEEP_NARROW);
        if (bus_we && !slot.top) begin
            if (slot.tgt == TGT_INPUT) load_we[slot.ch] = 1'b1;
            if (slot.tgt == TGT_PAGE)  load_we = sel_q;
        end
        trig_mask = (bus_we && slot.tgt == TGT_TRIG) ? bus_wdata[NCH-1:0] : '0;
    end
endmodule

// File: rtl/dacld_edge_sync.sv
module dacld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-1:0], pin_n};
    end

    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/dacld_chan_bank.sv
module dacld_chan_bank #(
    parameter int NCH = 2,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    load_we,
    input  logic [CW-1:0]     load_code,
    input  logic [NCH-1:0]    copy_mask,
    output logic [NCH*CW-1:0] in_flat,
    output logic [NCH*CW-1:0] act_flat
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CW-1:0] in_q, act_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                in_q  <= '0;
                act_q <= '0;
            end else begin
                if (load_we[g])   in_q  <= load_code;
                if (copy_mask[g]) act_q <= in_q;
            end
        end
        assign in_flat[g*CW +: CW]  = in_q;
        assign act_flat[g*CW +: CW] = act_q;
    end
endmodule

// File: rtl/dacld_top.sv
module dacld_top
    import dacld_pkg::*;
#(
    parameter int NCH         = NUM_CH,
    parameter int CW          = CODE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [6:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              hw_trig_n,
    output logic [NCH*CW-1:0] dac_code_o,
    output logic [NCH-1:0]    dac_en_o,
    output logic [NCH-1:0]    amp_en_o
);
    logic [NCH-1:0]    load_we, trig_mask, sel_q, dac_pd_q, amp_pd_q, copy_mask;
    logic [CW-1:0]     load_code;
    logic [NCH*CW-1:0] in_flat, act_flat;
    logic              hw_fall;

    dacld_regif #(.NCH(NCH), .CW(CW), .DROPB(NARROW_DROP)) u_regif (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .load_we(load_we), .load_code(load_code),
        .trig_mask(trig_mask), .sel_q(sel_q), .dac_pd_q(dac_pd_q),
        .amp_pd_q(amp_pd_q)
    );

    dacld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_n(hw_trig_n), .fall_o(hw_fall)
    );

    assign copy_mask = trig_mask | {NCH{hw_fall}};

    dacld_chan_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk(clk), .rst(rst), .load_we(load_we), .load_code(load_code),
        .copy_mask(copy_mask), .in_flat(in_flat), .act_flat(act_flat)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign dac_code_o[g*CW +: CW] = dac_pd_q[g] ? '0 : act_flat[g*CW +: CW];
        assign dac_en_o[g]            = ~dac_pd_q[g];
        assign amp_en_o[g]            = ~amp_pd_q[g];
    end
endmodule

// File: rtl/dacld_sva.sv
module dacld_sva
    import dacld_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [6:0]        bus_addr,
    input logic              hw_fall,
    input logic [NCH-1:0]    copy_mask,
    input logic [NCH-1:0]    sel_q,
    input logic [NCH*CW-1:0] in_flat,
    input logic [NCH*CW-1:0] act_flat
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        localparam logic [6:0] NLSB = ADR_IN_N0 + 7'(STRIDE_N * g) - 7'd1;

        p_copy_r4: assert property (@(posedge clk) disable iff (rst)
            copy_mask[g] |=> act_flat[g*CW +: CW] == $past(in_flat[g*CW +: CW]));

        p_hold_r2: assert property (@(posedge clk) disable iff (rst)
            !copy_mask[g] |=> $stable(act_flat[g*CW +: CW]));

        p_hw_copy_r5: assert property (@(posedge clk) disable iff (rst)
            hw_fall |=> act_flat[g*CW +: CW] == $past(in_flat[g*CW +: CW]));

        p_trunc_r3: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == NLSB) |=> in_flat[g*CW +: 4] == 4'h0);

        p_unsel_r6: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == ADR_PAGE_W - 7'd1 && !sel_q[g])
            |=> $stable(in_flat[g*CW +: CW]));
    end
endmodule

bind dacld_top dacld_sva #(.NCH(NCH), .CW(CW)) u_sva (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .hw_fall(hw_fall), .copy_mask(copy_mask), .sel_q(sel_q),
    .in_flat(in_flat), .act_flat(act_flat)
);

// File: tb/dacld_top_tb_top.sv
module dacld_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        hw_trig_n = 1'b1;
    logic [31:0] dac_code_o;
    logic [1:0]  dac_en_o, amp_en_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dacld_top dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .hw_trig_n(hw_trig_n), .dac_code_o(dac_code_o),
        .dac_en_o(dac_en_o), .amp_en_o(amp_en_o)
    );

    function automatic logic [15:0] code(input int ch);
        return dac_code_o[ch*16 +: 16];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 codes", dac_code_o, 32'h0);
        check("R1 dac_en", {30'd0, dac_en_o}, 32'h3);
        check("R1 amp_en", {30'd0, amp_en_o}, 32'h3);
    endtask

    task automatic t_wide();
        wr(7'h48, 8'hA5); wr(7'h47, 8'h3C); wr(7'h46, 8'hFF);
        check("R2 not live before trigger", {16'd0, code(0)}, 32'h0);
        wr(7'h45, 8'h01);
        check("R2 R4 ch0 copied", {16'd0, code(0)}, 32'hA53C);
        check("R4 ch1 unmasked kept", {16'd0, code(1)}, 32'h0);
    endtask

    task automatic t_narrow();
        wr(7'h36, 8'h12); wr(7'h35, 8'h3F);
        wr(7'h32, 8'h02);
        check("R3 narrow truncation", {16'd0, code(1)}, 32'h1230);
        check("R4 ch0 unmasked kept", {16'd0, code(0)}, 32'hA53C);
    endtask

    task automatic t_page();
        wr(7'h41, 8'h01);
        wr(7'h44, 8'h77); wr(7'h43, 8'h88); wr(7'h42, 8'h99);
        wr(7'h45, 8'h03);
        check("R6 selected ch0", {16'd0, code(0)}, 32'h7788);
        check("R6 unselected ch1", {16'd0, code(1)}, 32'h1230);
        wr(7'h2F, 8'h03);
        wr(7'h31, 8'h9A); wr(7'h30, 8'hBC);
        wr(7'h45, 8'h03);
        check("R6 narrow page both", dac_code_o, 32'h9AB0_9AB0);
    endtask

    task automatic t_stream();
        logic [7:0] bytes [7] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h03};
        @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            bus_we = 1'b1; bus_addr = 7'(7'h4B - i); bus_wdata = bytes[i];
            @(negedge clk);
        end
        bus_we = 1'b0;
        check("R7 burst ch1", {16'd0, code(1)}, 32'h1122);
        check("R7 burst ch0", {16'd0, code(0)}, 32'h4455);
    endtask

    task automatic t_hw();
        wr(7'h48, 8'hCA); wr(7'h47, 8'hFE);
        wr(7'h4B, 8'hBE); wr(7'h4A, 8'hEF);
        hw_trig_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R5 not yet after two edges", dac_code_o, 32'h1122_4455);
        @(negedge clk);
        check("R5 copy after third edge", dac_code_o, 32'hBEEF_CAFE);
        wr(7'h48, 8'h01); wr(7'h47, 8'h02);
        repeat (4) @(negedge clk);
        check("R5 low level no recopy", dac_code_o, 32'hBEEF_CAFE);
        hw_trig_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_coincide();
        wr(7'h4B, 8'h5A); wr(7'h4A, 8'h5B);
        hw_trig_n = 1'b0;
        @(negedge clk); @(negedge clk);
        bus_we = 1'b1; bus_addr = 7'h45; bus_wdata = 8'h01;
        @(negedge clk);
        bus_we = 1'b0;
        check("R10 coincident copy", dac_code_o, 32'h5A5B_0102);
        hw_trig_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pd();
        wr(7'h18, 8'h10);
        check("R8 pd ch0 code zero", {16'd0, code(0)}, 32'h0);
        check("R8 pd ch0 en", {30'd0, dac_en_o}, 32'h2);
        check("R8 ch1 unaffected", {16'd0, code(1)}, 32'h5A5B);
        wr(7'h18, 8'h02);
        check("R8 restored code kept", {16'd0, code(0)}, 32'h0102);
        check("R9 amp pd ch1", {30'd0, amp_en_o}, 32'h1);
        check("R9 dac_en back", {30'd0, dac_en_o}, 32'h3);
        wr(7'h18, 8'h00);
        check("R9 amp back", {30'd0, amp_en_o}, 32'h3);
    endtask

    task automatic t_unmapped();
        wr(7'h49, 8'hEE); wr(7'h50, 8'hFF); wr(7'h20, 8'h77); wr(7'h7F, 8'h33);
        wr(7'h45, 8'h03);
        check("R11 unmapped no effect", dac_code_o, 32'h5A5B_0102);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wide();
        t_narrow();
        t_page();
        t_stream();
        t_hw();
        t_coincide();
        t_pd();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule